// File: doc/BRIEF.md
# External Bus Read-Strobe Controller

This block runs read cycles on an asynchronous external parallel bus for an on-chip requester, typically a DMA engine pulling words from a converter or memory-mapped device. The requester hands over an address through a valid/ready handshake. The controller then drives an active-low chip select, an active-low read strobe and the registered address through three timed phases: lead, active and trail. It returns the sampled data word with a one-cycle valid pulse.

Each phase length is programmed in interface clock cycles and clamped to a safe floor. The lead phase has a floor of 2 cycles, the active phase 6 and the trail phase 1. The data bus is sampled on the last cycle of the active phase, so the sample point follows the strobe timing and not any clock at the external device. An optional ready input, passed through a two-flop synchronizer, can stretch the active phase. Cycles in which the synchronized ready is low do not count toward the active length, so once ready is high the phase still runs out its remaining cycles before the capture. Software must hold the configuration inputs constant from the acceptance of a request until the controller is idle again.

Top module: `xbus_rd_ctrl`

## Requirements
- R1: While rst_n is low and after its release with no request, bus_cs_n and bus_rd_n are 1, rsp_valid is 0 and req_ready is 1.
- R2: req_ready is 1 exactly while the controller is idle. A request is accepted on the clock edge where req_valid and req_ready are both 1. Its address appears on bus_addr from the next cycle and stays unchanged for as long as bus_cs_n stays 0.
- R3: The lead phase comes first after acceptance, with bus_cs_n at 0 and bus_rd_n at 1. It lasts max(cfg_lead, 2) cycles.
- R4: The active phase follows the lead phase, with bus_cs_n and bus_rd_n both 0. It lasts exactly max(cfg_active, 6) cycles when cfg_rdy_en is 0, or when the synchronized ready stays 1. It never lasts fewer than 6 cycles.
- R5: rsp_data takes the value of bus_data_in at the clock edge that ends the last active cycle. rsp_valid is 1 for exactly one cycle, the first cycle of the trail phase.
- R6: The trail phase follows the active phase, with bus_cs_n and bus_rd_n both 1 and req_ready 0. It lasts max(cfg_trail, 1) cycles. A req_valid held at 1 during the trail phase is not accepted before the controller is idle.
- R7: With cfg_rdy_en at 1, bus_rdy goes through a two-flop synchronizer. An active cycle in which the synchronized value is 0 does not count toward the active length. If bus_rdy is 0 from before acceptance and is first sampled as 1 at the edge ending active cycle k, the active phase lasts k + 1 + max(cfg_active, 6) cycles.
- R8: With cfg_rdy_en at 0, the level and activity of bus_rdy have no effect on any phase length or on the captured data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_lead | input | CW | Programmed lead length in cycles (floor 2) |
| cfg_active | input | CW | Programmed active length in cycles (floor 6) |
| cfg_trail | input | CW | Programmed trail length in cycles (floor 1) |
| cfg_rdy_en | input | 1 | 1 lets bus_rdy stretch the active phase |
| req_valid | input | 1 | Requester has a read address ready |
| req_ready | output | 1 | Controller idle and able to accept |
| req_addr | input | AW | Read address from the requester |
| rsp_valid | output | 1 | One-cycle pulse marking rsp_data as new |
| rsp_data | output | DW | Word captured from the external bus |
| bus_cs_n | output | 1 | Active-low chip select |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_addr | output | AW | Registered address driven to the bus |
| bus_data_in | input | DW | External data bus |
| bus_rdy | input | 1 | Asynchronous ready from the external device |

## Verification
On every cycle, the assertions check the strobe relationships. The read strobe only falls after at least two cycles of chip select. Idle never coincides with an asserted strobe. The address holds still under chip select. The strobe never stays low for fewer than six cycles. Each response pulse is a single cycle that lines up with the rising read strobe, inside a trail phase that is not idle. Only the bench's scenarios can show the exact clamped phase lengths for each setting, which clock edge's data word is returned, the stretch that a late ready adds through the synchronizer, and that a disabled ready input changes nothing.

// File: rtl/xbus_rd_pkg.sv
package xbus_rd_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_LEAD   = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_TRAIL  = 2'd3
  } xb_phase_e;

  // Floors applied to the programmed phase lengths.
  localparam int unsigned LEAD_MIN   = 2;
  localparam int unsigned ACTIVE_MIN = 6;
  localparam int unsigned TRAIL_MIN  = 1;

endpackage

// File: rtl/xbus_len_clamp.sv
module xbus_len_clamp #(
  parameter int unsigned CW  = 4,
  parameter int unsigned MIN = 1
) (
  input  logic [CW-1:0] len_raw,
  output logic [CW-1:0] len_eff
);

  localparam logic [CW-1:0] MinVal = CW'(MIN);

  always_comb begin
    if (len_raw < MinVal) begin
      len_eff = MinVal;
    end else begin
      len_eff = len_raw;
    end
  end

endmodule

// File: rtl/xbus_rdy_sync.sv
module xbus_rdy_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d_async};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign q_sync = sh_q[STAGES-1];

endmodule

// File: rtl/xbus_phase_ctr.sv
module xbus_phase_ctr #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  input  logic [CW-1:0] len,
  output logic          last
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr | adv;
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
    last   = (cnt_q == CW'(len - 1'b1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/xbus_rd_ctrl.sv
module xbus_rd_ctrl
  import xbus_rd_pkg::*;
#(
  parameter int unsigned AW          = 16,
  parameter int unsigned DW          = 16,
  parameter int unsigned CW          = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_lead,
  input  logic [CW-1:0] cfg_active,
  input  logic [CW-1:0] cfg_trail,
  input  logic          cfg_rdy_en,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          bus_cs_n,
  output logic          bus_rd_n,
  output logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data_in,
  input  logic          bus_rdy
);

  xb_phase_e     phase_q, phase_d;
  logic [CW-1:0] lead_len, act_len, trail_len, cur_len;
  logic          rdy_s;
  logic          step, last, ends, accept, cap_en, ph_chg;
  logic          cs_n_d, rd_n_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          vld_q, cs_n_q, rd_n_q;

  // Length clamps
  xbus_len_clamp #(.CW(CW), .MIN(LEAD_MIN)) u_clamp_lead (
    .len_raw(cfg_lead), .len_eff(lead_len));
  xbus_len_clamp #(.CW(CW), .MIN(ACTIVE_MIN)) u_clamp_act (
    .len_raw(cfg_active), .len_eff(act_len));
  xbus_len_clamp #(.CW(CW), .MIN(TRAIL_MIN)) u_clamp_trail (
    .len_raw(cfg_trail), .len_eff(trail_len));

  // Ready synchronizer
  xbus_rdy_sync #(.STAGES(SYNC_STAGES)) u_rdy_sync (
    .clk(clk), .rst_n(rst_n), .d_async(bus_rdy), .q_sync(rdy_s));

  // Phase counter
  xbus_phase_ctr #(.CW(CW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clr(ph_chg), .adv(step),
    .len(cur_len), .last(last));

  // Next-state logic
  always_comb begin
    accept  = req_valid && (phase_q == PH_IDLE);
    cur_len = lead_len;
    step    = 1'b0;
    unique case (phase_q)
      PH_LEAD:   begin cur_len = lead_len;  step = 1'b1; end
      PH_ACTIVE: begin cur_len = act_len;   step = !cfg_rdy_en || rdy_s; end
      PH_TRAIL:  begin cur_len = trail_len; step = 1'b1; end
      default:   begin cur_len = lead_len;  step = 1'b0; end
    endcase
    ends    = step && last;
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:   if (accept) phase_d = PH_LEAD;
      PH_LEAD:   if (ends)   phase_d = PH_ACTIVE;
      PH_ACTIVE: if (ends)   phase_d = PH_TRAIL;
      PH_TRAIL:  if (ends)   phase_d = PH_IDLE;
      default:               phase_d = PH_IDLE;
    endcase
    ph_chg = (phase_d != phase_q);
    cap_en = (phase_q == PH_ACTIVE) && ends;
    cs_n_d = !((phase_d == PH_LEAD) || (phase_d == PH_ACTIVE));
    rd_n_d = !(phase_d == PH_ACTIVE);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cs_n_q  <= 1'b1;
      rd_n_q  <= 1'b1;
      vld_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cs_n_q  <= cs_n_d;
      rd_n_q  <= rd_n_d;
      vld_q   <= cap_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (accept) begin
      addr_q <= req_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (cap_en) begin
      data_q <= bus_data_in;
    end
  end

  assign req_ready = (phase_q == PH_IDLE);
  assign rsp_valid = vld_q;
  assign rsp_data  = data_q;
  assign bus_cs_n  = cs_n_q;
  assign bus_rd_n  = rd_n_q;
  assign bus_addr  = addr_q;

endmodule

// File: rtl/xbus_rd_ctrl_chk.sv
module xbus_rd_ctrl_chk
  import xbus_rd_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          bus_cs_n,
  input logic          bus_rd_n,
  input logic [AW-1:0] bus_addr
);

  logic [7:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run <= '0;
    end else if (bus_rd_n) begin
      low_run <= '0;
    end else if (low_run != 8'hFF) begin
      low_run <= low_run + 8'd1;
    end
  end

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (bus_cs_n && bus_rd_n));

  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_cs_n && !$past(bus_cs_n)) |-> $stable(bus_addr));

  assert_lead_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_rd_n) |-> (!$past(bus_cs_n) && !$past(bus_cs_n, 2)));

  assert_strobe_in_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> !bus_cs_n);

  assert_active_min_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rd_n) |-> (low_run >= 8'(ACTIVE_MIN)));

  assert_rsp_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $rose(bus_rd_n));

  assert_rsp_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_trail_min_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rd_n) |-> (!req_ready && bus_cs_n));

endmodule

bind xbus_rd_ctrl xbus_rd_ctrl_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .bus_cs_n (bus_cs_n),
  .bus_rd_n (bus_rd_n),
  .bus_addr (bus_addr)
);

// File: tb/xbus_rd_ctrl_test.sv
module xbus_rd_ctrl_test;

  localparam int AW = 16;
  localparam int DW = 16;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] cfg_lead = '0, cfg_active = '0, cfg_trail = '0;
  logic          cfg_rdy_en = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic          bus_cs_n, bus_rd_n;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_data_in = '0;
  logic          bus_rdy = 1'b0;

  int n_run = 0;
  int n_fail = 0;
  int tick = 0;

  always #4 clk = ~clk;

  xbus_rd_ctrl #(.AW(AW), .DW(DW), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_lead(cfg_lead), .cfg_active(cfg_active), .cfg_trail(cfg_trail),
    .cfg_rdy_en(cfg_rdy_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_addr(bus_addr),
    .bus_data_in(bus_data_in), .bus_rdy(bus_rdy));

  function automatic int floor_at(input int v, input int m);
    return (v < m) ? m : v;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One read; k > 0 raises bus_rdy on the k-th active cycle, tog toggles bus_rdy,
  // hold keeps req_valid high until idle is seen again.
  task automatic run_rd(input logic [AW-1:0] a, input int l, input int ac,
                        input int t, input bit ren, input int k,
                        input bit tog, input bit hold, input string areq);
    int nl = 0, na = 0, nt = 0, nv = 0, bad_addr = 0, guard = 0;
    int exp_l, exp_a, exp_t;
    logic [DW-1:0] last_d = '0, got_d = '0;
    bit started = 0, done = 0;
    exp_l = floor_at(l, 2);
    exp_t = floor_at(t, 1);
    exp_a = floor_at(ac, 6) + ((ren && k > 0) ? k + 1 : 0);
    @(negedge clk);
    cfg_lead   = CW'(l);
    cfg_active = CW'(ac);
    cfg_trail  = CW'(t);
    cfg_rdy_en = ren;
    bus_rdy    = (ren && k == 0) ? 1'b1 : 1'b0;
    req_addr   = a;
    req_valid  = 1'b1;
    while (!done && guard < 200) begin
      @(negedge clk);
      guard++;
      tick++;
      if (tog) bus_rdy = tick[0];
      if (rsp_valid) begin nv++; got_d = rsp_data; end
      if (!bus_cs_n) begin
        started = 1;
        if (!hold) req_valid = 1'b0;
        if (bus_addr != a) bad_addr++;
      end
      if (!bus_cs_n && bus_rd_n) begin
        nl++;
      end else if (!bus_rd_n) begin
        na++;
        if (ren && k > 0 && na == k) bus_rdy = 1'b1;
      end else if (started && !req_ready) begin
        nt++;
      end else if (started && req_ready) begin
        done = 1;
        req_valid = 1'b0;
      end
      bus_data_in = DW'(tick * 37) ^ 16'h1234;
      if (!bus_rd_n) last_d = bus_data_in;
    end
    check(done, "R2", "read completed", int'(done), 1);
    check(bad_addr == 0, "R2", "address mismatches under chip select", bad_addr, 0);
    check(nl == exp_l, "R3", "lead length", nl, exp_l);
    check(na == exp_a, areq, "active length", na, exp_a);
    check(nt == exp_t, hold ? "R6" : "R6", "trail length", nt, exp_t);
    check(nv == 1, "R5", "valid pulse count", nv, 1);
    check(got_d == last_d, "R5", "captured word", int'(got_d), int'(last_d));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual expired expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    int acts[5] = '{0, 5, 6, 7, 9};
    repeat (3) @(negedge clk);
    // R1: reset state while held and after release
    check(bus_cs_n == 1'b1 && bus_rd_n == 1'b1, "R1", "strobes in reset",
          int'({bus_cs_n, bus_rd_n}), 3);
    check(rsp_valid == 1'b0, "R1", "rsp_valid in reset", int'(rsp_valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(req_ready == 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);
    check(bus_cs_n == 1'b1 && bus_rd_n == 1'b1, "R1", "strobes after reset",
          int'({bus_cs_n, bus_rd_n}), 3);

    // R3 R4 R5 R6: sweep of lengths, ready disabled
    for (int l = 0; l <= 4; l++) begin
      for (int ai = 0; ai < 5; ai++) begin
        for (int t = 0; t <= 2; t++) begin
          run_rd(AW'(l * 100 + ai * 10 + t) ^ 16'hA5C3, l, acts[ai], t,
                 1'b0, 0, 1'b0, 1'b0, "R4");
        end
      end
    end

    // R4 with ready enabled and held high
    for (int ac = 4; ac <= 8; ac++) begin
      run_rd(AW'(16'h7000 + ac), 2, ac, 1, 1'b1, 0, 1'b0, 1'b0, "R4");
    end

    // R7: late ready stretches the active phase
    for (int k = 1; k <= 4; k++) begin
      run_rd(AW'(16'h3100 + k), 2, 6, 1, 1'b1, k, 1'b0, 1'b0, "R7");
      run_rd(AW'(16'h3200 + k), 3, 8, 2, 1'b1, k, 1'b0, 1'b0, "R7");
    end

    // R8: ready disabled, bus_rdy toggling every cycle
    for (int ac = 0; ac <= 9; ac += 3) begin
      run_rd(AW'(16'h8800 + ac), 1, ac, 1, 1'b0, 0, 1'b1, 1'b0, "R8");
    end

    // R6: request held high through the trail phase
    for (int t = 0; t <= 3; t++) begin
      run_rd(AW'(16'hC0C0 + t), 2, 6, t, 1'b0, 0, 1'b0, 1'b1, "R4");
    end
    @(negedge clk);
    check(req_ready == 1'b1 && bus_cs_n == 1'b1, "R6", "idle after held request",
          int'({req_ready, bus_cs_n}), 3);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule